// File: doc/BRIEF.md
# Early-Translation Load Address Fast Path

This block sits at the front of a load pipeline and decides, for each incoming load, how quickly its address can be translated and its result returned. A load brings a base value, an optional scaled index, a signed displacement, and two hints: whether the base came straight from an earlier load, and whether the index register was cleared by a zeroing idiom. The block forms the full 48-bit address. It classifies the address as simple or complex and chooses one of three completion paths: fast, normal or replayed. Each load completes under its own tag after a latency that the path fixes.

The fast path starts translation from the page of the base register while the full sum is still being formed. When the displacement carries the address into another 4 KiB page, that early guess is wrong. The load is then replayed at a higher cost, and the next load is barred from trying the fast path. A two-state controller holds this history. In state `SPEC` fast attempts are allowed. In state `FORCED` every load takes the normal path. Reset enters `SPEC`. Accepting a load whose fast attempt misses its page moves `SPEC` to `FORCED`. Accepting any load in `FORCED` moves back to `SPEC`.

Completions are scheduled on a ring of slots indexed by completion cycle, so a short-latency load can overtake a longer one. The input stalls when the slot for the load's completion cycle is already taken.

Top module: `lat_fastpath`

## Requirements
- R1: An address is simple when no index is live and the offset lies in 0..2047 inclusive. A simple address whose base came from a load (in_base_from_load=1), presented in state `SPEC`, tries the fast path.
- R2: A negative offset, an offset of 2048 or more, or a live index makes the address complex, and a complex load takes the normal path.
- R3: A load whose base came from an ALU result (in_base_from_load=0) takes the normal path even when its address is simple.
- R4: An index with in_has_index=1 is live unless in_index_zeroed=1. An index flagged as zeroed keeps the address simple and adds nothing. An index of value zero without the flag makes the address complex.
- R5: out_path codes: 0 normal, 1 fast, 2 replay. The out_latency values are 5, 4 and 10 respectively. out_valid rises exactly out_latency clock edges after the edge that accepted the load.
- R6: A fast attempt whose base and final address differ in bits [47:12] completes on the replay path with latency 10.
- R7: The load accepted after a replayed load takes the normal path. The controller then returns to `SPEC`, so a stream of page-crossing fast candidates alternates between 10 and 5 cycles.
- R8: out_addr equals base + (index << scale) + the sign-extended offset, modulo 2^48, with the index counted only when it is live.
- R9: Completions return with their own tag, out of order when latencies differ. in_ready is low while the completion slot for the presented load is occupied.
- R10: Reset empties every in-flight slot, so no completion appears for loads accepted before reset. It also returns the controller to `SPEC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A load is presented |
| in_ready | output | 1 | The presented load can be accepted this cycle |
| in_tag | input | TAG_W | Tag returned with the completion |
| in_base | input | VA_W | Base register value |
| in_base_from_load | input | 1 | Base was produced directly by an earlier load |
| in_has_index | input | 1 | Addressing form includes an index register |
| in_index | input | VA_W | Index register value |
| in_scale | input | SCALE_W | Index shift amount |
| in_index_zeroed | input | 1 | Index was cleared by a zeroing idiom |
| in_offset | input | OFF_W | Signed displacement |
| out_valid | output | 1 | A load completes this cycle |
| out_tag | output | TAG_W | Tag of the completing load |
| out_addr | output | VA_W | Final address |
| out_path | output | 2 | Path taken (0 normal, 1 fast, 2 replay) |
| out_latency | output | LAT_W | Cycles from accept to completion |

## Verification
The bench uses the default parameters: a 48-bit address, 4-bit tags, a 16-slot completion ring and latencies of 4, 5 and 10. Sixteen slots are enough for a 10-cycle replay to be overtaken by later 5-cycle loads, so back-to-back page crossings exercise out-of-order return and the 10/5 alternation together. The short gap between the fast and normal latencies lets a fast load issued one cycle after a normal load collide with it in the same slot, which reaches the stall. A 32-bit offset against a 48-bit address covers sign extension and wrap below zero.

// File: rtl/lat_pkg.sv
package lat_pkg;

    typedef enum logic [1:0] {
        PATH_NORMAL = 2'd0,
        PATH_FAST   = 2'd1,
        PATH_REPLAY = 2'd2
    } path_e;

    typedef enum logic {
        MODE_SPEC   = 1'b0,
        MODE_FORCED = 1'b1
    } mode_e;

endpackage

// File: rtl/lat_agu.sv
// Address sum, simple/complex classification and base-page check.
module lat_agu #(
    parameter int VA_W         = 48,
    parameter int OFF_W        = 32,
    parameter int SCALE_W      = 2,
    parameter int PAGE_LSB     = 12,
    parameter int SIMPLE_LIMIT = 2048
) (
    input  logic [VA_W-1:0]    base,
    input  logic               has_index,
    input  logic [VA_W-1:0]    index,
    input  logic [SCALE_W-1:0] scale,
    input  logic               index_zeroed,
    input  logic [OFF_W-1:0]   offset,
    output logic [VA_W-1:0]    addr,
    output logic               simple,
    output logic               page_cross
);
    logic              idx_live;
    logic [VA_W-1:0]   idx_term;
    logic [VA_W-1:0]   off_ext;
    logic              off_small;

    assign idx_live   = has_index && !index_zeroed;
    assign idx_term   = idx_live ? (index << scale) : '0;
    assign off_ext    = {{(VA_W-OFF_W){offset[OFF_W-1]}}, offset};
    assign addr       = base + idx_term + off_ext;
    assign off_small  = !offset[OFF_W-1] && (offset < OFF_W'(SIMPLE_LIMIT));
    assign simple     = !idx_live && off_small;
    assign page_cross = base[VA_W-1:PAGE_LSB] != addr[VA_W-1:PAGE_LSB];
endmodule

// File: rtl/lat_wheel.sv
// Completion ring: one slot per future cycle, read and cleared as the pointer passes.
module lat_wheel
    import lat_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TAG_W = 4,
    parameter int VA_W  = 48,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LAT_W-1:0] wr_delay,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [VA_W-1:0]  wr_addr,
    input  path_e            wr_path,
    input  logic [LAT_W-1:0] probe_delay,
    output logic             probe_busy,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic [VA_W-1:0]  out_addr,
    output path_e            out_path,
    output logic [LAT_W-1:0] out_lat
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] probe_idx;
    logic             slot_v    [DEPTH];
    logic [TAG_W-1:0] slot_tag  [DEPTH];
    logic [VA_W-1:0]  slot_addr [DEPTH];
    path_e            slot_path [DEPTH];
    logic [LAT_W-1:0] slot_lat  [DEPTH];

    assign wr_idx     = ptr + IDX_W'(wr_delay);
    assign probe_idx  = ptr + IDX_W'(probe_delay);
    assign probe_busy = slot_v[probe_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr + 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                slot_v[g] <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(g))     slot_v[g] <= 1'b1;
            else if (ptr == IDX_W'(g))                 slot_v[g] <= 1'b0;
        end
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(g)) begin
                slot_tag[g]  <= wr_tag;
                slot_addr[g] <= wr_addr;
                slot_path[g] <= wr_path;
                slot_lat[g]  <= wr_delay;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= slot_v[ptr];
    end

    always_ff @(posedge clk) begin
        out_tag  <= slot_tag[ptr];
        out_addr <= slot_addr[ptr];
        out_path <= slot_path[ptr];
        out_lat  <= slot_lat[ptr];
    end
endmodule

// File: rtl/lat_fastpath.sv
// Top: path controller (SPEC / FORCED) over the address unit and completion ring.
module lat_fastpath
    import lat_pkg::*;
#(
    parameter int VA_W         = 48,
    parameter int OFF_W        = 32,
    parameter int SCALE_W      = 2,
    parameter int TAG_W        = 4,
    parameter int PAGE_LSB     = 12,
    parameter int SIMPLE_LIMIT = 2048,
    parameter int LAT_FAST     = 4,
    parameter int LAT_NORMAL   = 5,
    parameter int LAT_REPLAY   = 10,
    parameter int SLOT_DEPTH   = 16,
    localparam int LAT_W       = $clog2(LAT_REPLAY + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [TAG_W-1:0]   in_tag,
    input  logic [VA_W-1:0]    in_base,
    input  logic               in_base_from_load,
    input  logic               in_has_index,
    input  logic [VA_W-1:0]    in_index,
    input  logic [SCALE_W-1:0] in_scale,
    input  logic               in_index_zeroed,
    input  logic [OFF_W-1:0]   in_offset,
    output logic               out_valid,
    output logic [TAG_W-1:0]   out_tag,
    output logic [VA_W-1:0]    out_addr,
    output logic [1:0]         out_path,
    output logic [LAT_W-1:0]   out_latency
);
    mode_e            mode_q, mode_d;
    path_e            sel_path, ring_path;
    logic [LAT_W-1:0] sel_lat;
    logic [VA_W-1:0]  agu_addr;
    logic             agu_simple, agu_cross;
    logic             fast_try, tgt_busy, accept;

    lat_agu #(
        .VA_W(VA_W), .OFF_W(OFF_W), .SCALE_W(SCALE_W),
        .PAGE_LSB(PAGE_LSB), .SIMPLE_LIMIT(SIMPLE_LIMIT)
    ) u_agu (
        .base(in_base), .has_index(in_has_index), .index(in_index),
        .scale(in_scale), .index_zeroed(in_index_zeroed), .offset(in_offset),
        .addr(agu_addr), .simple(agu_simple), .page_cross(agu_cross)
    );

    assign in_ready = !tgt_busy;
    assign accept   = in_valid && in_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_SPEC;
        else        mode_q <= mode_d;
    end

    // next state
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_SPEC:   if (accept && sel_path == PATH_REPLAY) mode_d = MODE_FORCED;
            MODE_FORCED: if (accept)                            mode_d = MODE_SPEC;
        endcase
    end

    // outputs: path and latency for the presented load
    always_comb begin
        fast_try = 1'b0;
        sel_path = PATH_NORMAL;
        unique case (mode_q)
            MODE_SPEC: begin
                fast_try = agu_simple && in_base_from_load;
                if (fast_try) sel_path = agu_cross ? PATH_REPLAY : PATH_FAST;
            end
            MODE_FORCED: sel_path = PATH_NORMAL;
        endcase
        sel_lat = LAT_W'(LAT_NORMAL);
        unique case (sel_path)
            PATH_FAST:   sel_lat = LAT_W'(LAT_FAST);
            PATH_REPLAY: sel_lat = LAT_W'(LAT_REPLAY);
            default:     sel_lat = LAT_W'(LAT_NORMAL);
        endcase
    end

    lat_wheel #(
        .DEPTH(SLOT_DEPTH), .TAG_W(TAG_W), .VA_W(VA_W), .LAT_W(LAT_W)
    ) u_ring (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept), .wr_delay(sel_lat), .wr_tag(in_tag),
        .wr_addr(agu_addr), .wr_path(sel_path),
        .probe_delay(sel_lat), .probe_busy(tgt_busy),
        .out_valid(out_valid), .out_tag(out_tag), .out_addr(out_addr),
        .out_path(ring_path), .out_lat(out_latency)
    );

    assign out_path = ring_path;
endmodule

// File: rtl/lat_fastpath_chk.sv
module lat_fastpath_chk #(
    parameter int LAT_W      = 4,
    parameter int LAT_FAST   = 4,
    parameter int LAT_NORMAL = 5,
    parameter int LAT_REPLAY = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             accept,
    input logic             mode_q,
    input logic [1:0]       sel_path,
    input logic             out_valid,
    input logic [1:0]       out_path,
    input logic [LAT_W-1:0] out_latency
);
    // R5
    lat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_path == 2'd0 && out_latency == LAT_W'(LAT_NORMAL)) ||
                       (out_path == 2'd1 && out_latency == LAT_W'(LAT_FAST))   ||
                       (out_path == 2'd2 && out_latency == LAT_W'(LAT_REPLAY))));

    // R7
    forced_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_q) |-> sel_path == 2'd0);

    // R7
    enter_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sel_path == 2'd2) |=> mode_q);

    // R7
    leave_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_q) |=> !mode_q);

    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mode_q && !out_valid));
endmodule

bind lat_fastpath lat_fastpath_chk #(
    .LAT_W(LAT_W), .LAT_FAST(LAT_FAST), .LAT_NORMAL(LAT_NORMAL), .LAT_REPLAY(LAT_REPLAY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .accept(accept), .mode_q(mode_q),
    .sel_path(sel_path), .out_valid(out_valid), .out_path(out_path),
    .out_latency(out_latency)
);

// File: tb/sim_lat_fastpath.sv
module sim_lat_fastpath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_tag = '0;
    logic [47:0] in_base = '0;
    logic        in_base_from_load = 1'b0;
    logic        in_has_index = 1'b0;
    logic [47:0] in_index = '0;
    logic [1:0]  in_scale = '0;
    logic        in_index_zeroed = 1'b0;
    logic [31:0] in_offset = '0;
    logic        out_valid;
    logic [3:0]  out_tag;
    logic [47:0] out_addr;
    logic [1:0]  out_path;
    logic [3:0]  out_latency;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lat_fastpath u0 (.*);

    // monitor, sampling at the falling edge
    logic        got      [16];
    int          acc_cyc  [16];
    int          done_cyc [16];
    logic [47:0] got_addr [16];
    logic [1:0]  got_path [16];
    logic [3:0]  got_lat  [16];

    always @(negedge clk) begin
        if (rst_n) begin
            if (in_valid && in_ready) acc_cyc[in_tag] = cyc + 1;
            if (out_valid) begin
                got[out_tag]      = 1'b1;
                done_cyc[out_tag] = cyc;
                got_addr[out_tag] = out_addr;
                got_path[out_tag] = out_path;
                got_lat[out_tag]  = out_latency;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_got();
        for (int i = 0; i < 16; i++) got[i] = 1'b0;
    endtask

    // called at posedge+2; returns after the accepting edge, at posedge+2
    task automatic send(input logic [3:0] tag, input logic [47:0] base, input logic from_load,
                        input logic has_idx, input logic [47:0] idx, input logic [1:0] scale,
                        input logic zeroed, input logic [31:0] off, output int stalls);
        in_tag = tag; in_base = base; in_base_from_load = from_load;
        in_has_index = has_idx; in_index = idx; in_scale = scale;
        in_index_zeroed = zeroed; in_offset = off; in_valid = 1'b1;
        stalls = 0;
        #1;
        while (!in_ready) begin
            stalls++;
            @(posedge clk); #2;
        end
        @(posedge clk); #2;
        in_valid = 1'b0;
    endtask

    task automatic wait_for(input logic [3:0] tag);
        int n = 0;
        while (!got[tag] && n < 30) begin
            @(posedge clk); #2;
            n++;
        end
    endtask

    typedef struct packed {
        logic [47:0] base;
        logic        from_load;
        logic        has_idx;
        logic [47:0] idx;
        logic [1:0]  scale;
        logic        zeroed;
        logic [31:0] off;
        logic [1:0]  exp_path;
        logic [3:0]  exp_lat;
        logic [47:0] exp_addr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{48'h1234_5000, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h80,        2'd1, 4'd4,  48'h1234_5080, 4'd1},  // R1
        '{48'h1234_5000, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h7FF,       2'd1, 4'd4,  48'h1234_57FF, 4'd1},  // R1 edge
        '{48'h1234_5000, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h800,       2'd0, 4'd5,  48'h1234_5800, 4'd2},  // R2
        '{48'h1234_5100, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'hFFFF_FFF8, 2'd0, 4'd5,  48'h1234_50F8, 4'd2},  // R2 negative
        '{48'h1234_5000, 1'b0, 1'b0, 48'h0, 2'd0, 1'b0, 32'h10,        2'd0, 4'd5,  48'h1234_5010, 4'd3},  // R3
        '{48'h1234_5000, 1'b1, 1'b1, 48'h0, 2'd2, 1'b1, 32'h20,        2'd1, 4'd4,  48'h1234_5020, 4'd4},  // R4 zeroed
        '{48'h1234_5000, 1'b1, 1'b1, 48'h0, 2'd2, 1'b0, 32'h20,        2'd0, 4'd5,  48'h1234_5020, 4'd4},  // R4 plain zero
        '{48'h1234_5000, 1'b1, 1'b1, 48'h3, 2'd2, 1'b0, 32'h4,         2'd0, 4'd5,  48'h1234_5010, 4'd8},  // R8 scaled
        '{48'h1234_5F80, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h100,       2'd2, 4'd10, 48'h1234_6080, 4'd6},  // R6
        '{48'h1234_5000, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h8,         2'd0, 4'd5,  48'h1234_5008, 4'd7},  // R7 forced
        '{48'h1234_5000, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h8,         2'd1, 4'd4,  48'h1234_5008, 4'd7},  // R7 back to fast
        '{48'h0000_0010, 1'b0, 1'b0, 48'h0, 2'd0, 1'b0, 32'hFFFF_FFE0, 2'd0, 4'd5,  48'hFFFF_FFFF_FFF0, 4'd8}, // R8 wrap
        '{48'h1234_5FF0, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h10,        2'd2, 4'd10, 48'h1234_6000, 4'd6},  // R6
        '{48'h1234_5FF0, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h10,        2'd0, 4'd5,  48'h1234_6000, 4'd7},  // R7
        '{48'h1234_5FF0, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h10,        2'd2, 4'd10, 48'h1234_6000, 4'd7}   // R7
    };

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int st;
        string rq;
        clear_got();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;

        // R10 reset state
        chk(out_valid == 1'b0, "R10", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'd1);

        // table walk: one load at a time
        for (int v = 0; v < NV; v++) begin
            clear_got();
            send(4'(v), VECS[v].base, VECS[v].from_load, VECS[v].has_idx, VECS[v].idx,
                 VECS[v].scale, VECS[v].zeroed, VECS[v].off, st);
            wait_for(4'(v));
            rq = $sformatf("R%0d", VECS[v].req);
            chk(got[v] == 1'b1, rq, $sformatf("vec %0d completion", v), 64'(got[v]), 64'd1);
            chk(got_path[v] == VECS[v].exp_path, rq, $sformatf("vec %0d path", v),
                64'(got_path[v]), 64'(VECS[v].exp_path));
            chk(got_lat[v] == VECS[v].exp_lat, rq, $sformatf("vec %0d latency field", v),
                64'(got_lat[v]), 64'(VECS[v].exp_lat));
            chk(done_cyc[v] - acc_cyc[v] == int'(VECS[v].exp_lat), "R5",
                $sformatf("vec %0d measured latency", v),
                64'(done_cyc[v] - acc_cyc[v]), 64'(VECS[v].exp_lat));
            chk(got_addr[v] == VECS[v].exp_addr, "R8", $sformatf("vec %0d address", v),
                64'(got_addr[v]), 64'(VECS[v].exp_addr));
        end

        // R10: reset clears forced mode left by the last vector
        rst_n = 1'b0;
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(posedge clk); #2;

        // R7 / R9: four page-crossing fast candidates back to back
        clear_got();
        for (int t = 0; t < 4; t++)
            send(4'(t), 48'h1234_5FF0, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h10, st);
        wait_for(4'd2);
        for (int t = 0; t < 4; t++) begin
            chk(got_lat[t] == ((t % 2 == 0) ? 4'd10 : 4'd5), "R7",
                $sformatf("burst tag %0d latency", t), 64'(got_lat[t]),
                (t % 2 == 0) ? 64'd10 : 64'd5);
            chk(done_cyc[t] - acc_cyc[t] == ((t % 2 == 0) ? 10 : 5), "R7",
                $sformatf("burst tag %0d measured", t), 64'(done_cyc[t] - acc_cyc[t]),
                (t % 2 == 0) ? 64'd10 : 64'd5);
        end
        // R9 out-of-order return
        chk(done_cyc[1] < done_cyc[0], "R9", "tag1 before tag0",
            64'(done_cyc[1]), 64'(done_cyc[0]));

        // R9: fast load right after a normal load targets the same slot
        repeat (4) @(posedge clk);
        #0;
        clear_got();
        send(4'd8, 48'h1234_5000, 1'b0, 1'b0, 48'h0, 2'd0, 1'b0, 32'h40, st);
        send(4'd9, 48'h1234_5000, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h40, st);
        chk(st == 1, "R9", "stall cycles on slot clash", 64'(st), 64'd1);
        wait_for(4'd9);
        chk(got[8] && got[9], "R9", "both tags returned", 64'({got[8], got[9]}), 64'd3);
        chk(got_path[9] == 2'd1, "R9", "stalled load path", 64'(got_path[9]), 64'd1);
        chk(done_cyc[9] == done_cyc[8] + 1, "R9", "completion order after stall",
            64'(done_cyc[9]), 64'(done_cyc[8] + 1));

        // R10: reset while a replay is in flight
        clear_got();
        send(4'd5, 48'h1234_5FF0, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h10, st);
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (15) @(posedge clk);
        #2;
        chk(got[5] == 1'b0, "R10", "flushed load completion", 64'(got[5]), 64'd0);
        send(4'd6, 48'h1234_5000, 1'b1, 1'b0, 48'h0, 2'd0, 1'b0, 32'h8, st);
        wait_for(4'd6);
        chk(got_path[6] == 2'd1, "R10", "fast allowed after reset", 64'(got_path[6]), 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule